// File: doc/BRIEF.md
# Row-Register Cache Hit/Miss Engine

This block is a clocked model of the control core of a DRAM that carries a one-row cache. All strobes are active low and are sampled on the system clock. A falling edge of the row strobe starts an operation. At that edge the block decodes the operation from the mode pins and compares the multiplexed address, taken as a row, against a last-read row tag. From that comparison it runs a read hit, a read miss, a write hit or a write miss. A refresh request is passed out on its own pin.

The cache holds one full row of `2**ADDR_W` single-bit columns. Only a read miss changes the tag, and a read miss also copies the row from the array. Writes always go to the array. They reach the cache only when the row matches the tag. The output bit is always read from the cache, so a read works with the row strobe high or low. Inside, the cache is held as words of four bits: the low column bits pick a word, and the top two column bits pick one bit of that word. A change in only the top two bits therefore reaches the output one cycle sooner. After a write miss the output is muted until a settable number of cycles after the row strobe returns high.

The array is kept at a reduced depth of `2**ROW_SEL_W` rows, selected by the low row bits. The tag still compares the full row address, so two rows that share a slot are different pages to the cache.

FSM states: IDLE (waiting for a falling row edge), READ, WR_HIT, WR_MISS, REFRESH, RECOVER. The transitions are:
- IDLE→REFRESH on a fall with refresh low.
- IDLE→READ on a read fall.
- IDLE→WR_HIT or IDLE→WR_MISS on a write fall, depending on the tag compare.
- READ, WR_HIT and REFRESH→IDLE when the row strobe is high.
- WR_MISS→RECOVER when the row strobe is high.
- RECOVER→IDLE when its counter expires.

Top module: `rowcache_engine`

## Requirements
- R1: In reset `q`, `q_vld` and `ref_req` are 0 and the tag is invalid. Every access therefore misses until the first read miss, and that includes row 0.
- R2: A read starts on a falling row edge with `cs_n`=0, `ref_n`=1, `wr_sel`=0 and `cal_n`=1. On a miss the array row is copied into the cache and the tag is set to the row.
- R3: On a read hit the cache is not reloaded. Cache bits keep their values even when the array copy of that row has since changed.
- R4: A write starts on a falling row edge with `cs_n`=0, `ref_n`=1, `wr_sel`=1, `cal_n`=1 and `we_n`=1. On a write hit, committed bits go to both the array and the cache, and the output stays readable.
- R5: On a write miss only the array is written. `q_vld` is 0 from the cycle after the edge until `RECOV_CYC` cycles after the cycle that samples `row_n` high in WR_MISS.
- R6: A bit is committed only in a write state and only in a cycle with `cs_n`=0, `cal_n`=0 and `we_n`=0. The column is `addr` while `cal_n`=1. While `cal_n`=0 the column is the value held from the last cycle with `cal_n`=1.
- R7: `q_vld` in one cycle equals (`cs_n`=0 and `oe_n`=0 and not muted) in the cycle before. When `q_vld` is 0, `q` is 0. Reads with `row_n` high return the tagged row.
- R8: A falling row edge with `ref_n`=0 raises `ref_req` for exactly one cycle, one cycle later, whatever the state of `cs_n`. The cache stays readable during the refresh.
- R9: Column bit c is bit `c[ADDR_W-1:ADDR_W-2]` of word `c[ADDR_W-3:0]`. A change in only the top two column bits shows on `q` after one cycle. A change in the low bits shows on `q` after two cycles.
- R10: The array slot is the low `ROW_SEL_W` row bits, while the tag compares all `ADDR_W` bits. Two rows that share a slot share array data but are separate pages.
- R11: A falling edge that decodes to no operation is ignored. Examples are `cs_n`=1 without refresh, or `cal_n`=0. A falling edge seen in WR_MISS or RECOVER is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| row_n | input | 1 | Row strobe; its falling edge starts an operation |
| wr_sel | input | 1 | 1 selects write, 0 selects read at the row edge |
| ref_n | input | 1 | Refresh select, active low at the row edge |
| cal_n | input | 1 | Column latch; transparent high, holding low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row / column address |
| din | input | 1 | Write data bit |
| q | output | 1 | Read data bit (0 when not valid) |
| q_vld | output | 1 | Output driven flag |
| ref_req | output | 1 | One-cycle refresh request |

## Verification
The bench builds the block with ADDR_W=11, which gives a full 2048-column row, and with ROW_SEL_W=2, which gives four array slots. With only four slots, rows 0 and 4 alias. That makes it possible to reach the case where a read hit returns cache data that an aliased write miss has made stale in the array. The bench sets RECOV_CYC=4, so the recovery window is long enough to place an ignored falling edge inside it and to count exactly where `q_vld` returns.

// File: rtl/rowcache_pkg.sv
package rowcache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ    = 3'd1,
        ST_WR_HIT  = 3'd2,
        ST_WR_MISS = 3'd3,
        ST_REFRESH = 3'd4,
        ST_RECOVER = 3'd5
    } rc_state_t;

endpackage

// File: rtl/rc_ctl.sv
// Operation decode at the falling row edge, and the cycle state machine.
module rc_ctl
    import rowcache_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int ROW_SEL_W = 2,
    parameter int RECOV_CYC = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 row_n,
    input  logic                 wr_sel,
    input  logic                 ref_n,
    input  logic                 cal_n,
    input  logic                 we_n,
    input  logic                 oe_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [ADDR_W-1:0]    tag,
    input  logic                 tag_vld,
    output rc_state_t            st,
    output logic                 fill,
    output logic                 wr_commit,
    output logic                 wr_cache,
    output logic [ROW_SEL_W-1:0] wr_slot,
    output logic                 out_en,
    output logic                 ref_req
);
    localparam int CNT_W = $clog2(RECOV_CYC + 2);

    rc_state_t        st_nx;
    logic             row_q;
    logic [CNT_W-1:0] cnt;
    logic             fall, hit, dec_ref, dec_rd, dec_wr, idle;

    assign fall    = row_q & ~row_n;
    assign hit     = tag_vld && (addr == tag);
    assign dec_ref = fall && !ref_n;                                      // R8
    assign dec_rd  = fall && ref_n && !cs_n && !wr_sel && cal_n;          // R2
    assign dec_wr  = fall && ref_n && !cs_n && wr_sel && cal_n && we_n;   // R4
    assign idle    = (st == ST_IDLE);

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (dec_ref)     st_nx = ST_REFRESH;
                else if (dec_rd) st_nx = ST_READ;
                else if (dec_wr) st_nx = hit ? ST_WR_HIT : ST_WR_MISS;
            end
            ST_READ, ST_WR_HIT, ST_REFRESH: begin
                if (row_n) st_nx = ST_IDLE;
            end
            ST_WR_MISS: begin
                if (row_n) st_nx = (RECOV_CYC == 0) ? ST_IDLE : ST_RECOVER;
            end
            ST_RECOVER: begin
                if (cnt <= CNT_W'(1)) st_nx = ST_IDLE;                    // R11 falls here ignored
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            row_q   <= 1'b1;
            cnt     <= '0;
            wr_slot <= '0;
            ref_req <= 1'b0;
        end else begin
            st      <= st_nx;
            row_q   <= row_n;
            ref_req <= idle && dec_ref;
            if (idle && dec_wr) wr_slot <= addr[ROW_SEL_W-1:0];
            if (st == ST_WR_MISS && row_n) cnt <= CNT_W'(RECOV_CYC);
            else if (st == ST_RECOVER)     cnt <= cnt - CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        fill      = idle && dec_rd && !hit;                               // R2
        wr_commit = (st == ST_WR_HIT || st == ST_WR_MISS)
                    && !cs_n && !cal_n && !we_n;                          // R6
        wr_cache  = wr_commit && (st == ST_WR_HIT);                       // R4
        out_en    = !cs_n && !oe_n
                    && st != ST_WR_MISS && st != ST_RECOVER
                    && !(idle && dec_wr && !hit);                         // R5 R7
    end

endmodule

// File: rtl/rc_store.sv
// Array, cache row, tag and column latch.
module rc_store #(
    parameter int ADDR_W    = 11,
    parameter int ROW_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cal_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 din,
    input  logic                 fill,
    input  logic                 wr_commit,
    input  logic                 wr_cache,
    input  logic [ROW_SEL_W-1:0] wr_slot,
    output logic [ADDR_W-1:0]    tag,
    output logic                 tag_vld,
    output logic [ADDR_W-1:0]    col,
    output logic [3:0]           word
);
    localparam int COLS  = 1 << ADDR_W;
    localparam int ROWS  = 1 << ROW_SEL_W;
    localparam int SUB_W = ADDR_W - 2;

    logic [COLS-1:0]   arr [ROWS];
    logic [COLS-1:0]   cache;
    logic [ADDR_W-1:0] col_lat;

    assign col = cal_n ? addr : col_lat;                                  // R6

    generate
        for (genvar k = 0; k < 4; k++) begin : g_word
            assign word[k] = cache[{2'(k), col[SUB_W-1:0]}];              // R9
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) arr[i] <= '0;
            cache   <= '0;
            col_lat <= '0;
            tag     <= '0;
            tag_vld <= 1'b0;                                              // R1
        end else begin
            if (cal_n) col_lat <= addr;
            if (fill) begin
                cache   <= arr[addr[ROW_SEL_W-1:0]];                      // R10
                tag     <= addr;
                tag_vld <= 1'b1;
            end
            if (wr_commit) arr[wr_slot][col] <= din;
            if (wr_cache)  cache[col] <= din;
        end
    end

endmodule

// File: rtl/rc_outpath.sv
// Two-stage output: word fetch, then 4-to-1 bit select.
module rc_outpath (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       out_en,
    input  logic [3:0] word,
    input  logic [1:0] sel,
    output logic       q,
    output logic       q_vld
);
    logic [3:0] word_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_r <= '0;
            q      <= 1'b0;
            q_vld  <= 1'b0;
        end else begin
            word_r <= word;
            q      <= out_en ? word_r[sel] : 1'b0;                        // R7 R9
            q_vld  <= out_en;
        end
    end

endmodule

// File: rtl/rowcache_engine.sv
module rowcache_engine
    import rowcache_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int ROW_SEL_W = 2,
    parameter int RECOV_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              row_n,
    input  logic              wr_sel,
    input  logic              ref_n,
    input  logic              cal_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              q,
    output logic              q_vld,
    output logic              ref_req
);
    rc_state_t            st;
    logic                 fill, wr_commit, wr_cache, out_en, tag_vld;
    logic [ROW_SEL_W-1:0] wr_slot;
    logic [ADDR_W-1:0]    tag, col;
    logic [3:0]           word;

    rc_ctl #(.ADDR_W(ADDR_W), .ROW_SEL_W(ROW_SEL_W), .RECOV_CYC(RECOV_CYC)) u_ctl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .row_n(row_n), .wr_sel(wr_sel),
        .ref_n(ref_n), .cal_n(cal_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
        .tag(tag), .tag_vld(tag_vld), .st(st), .fill(fill), .wr_commit(wr_commit),
        .wr_cache(wr_cache), .wr_slot(wr_slot), .out_en(out_en), .ref_req(ref_req)
    );

    rc_store #(.ADDR_W(ADDR_W), .ROW_SEL_W(ROW_SEL_W)) u_store (
        .clk(clk), .rst_n(rst_n), .cal_n(cal_n), .addr(addr), .din(din),
        .fill(fill), .wr_commit(wr_commit), .wr_cache(wr_cache), .wr_slot(wr_slot),
        .tag(tag), .tag_vld(tag_vld), .col(col), .word(word)
    );

    rc_outpath u_out (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .word(word),
        .sel(col[ADDR_W-1 -: 2]), .q(q), .q_vld(q_vld)
    );

endmodule

// File: rtl/rc_checker.sv
module rc_checker
    import rowcache_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              oe_n,
    input logic              row_n,
    input logic              ref_n,
    input logic              q,
    input logic              q_vld,
    input logic              ref_req,
    input rc_state_t         st,
    input logic [ADDR_W-1:0] tag,
    input logic              fill
);
    AST_GATED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) || $past(oe_n)) |-> (!q_vld && !q));                 // R7
    AST_WMISS_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WR_MISS || st == ST_RECOVER) |=> !q_vld);               // R5
    AST_REF_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> ($past(!ref_n) && $past(!row_n)));                    // R8
    AST_REF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |=> !ref_req);                                            // R8
    AST_TAG_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tag) |-> $past(fill));                                   // R2
    AST_RECOVER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RECOVER) |-> ($past(st) == ST_WR_MISS || $past(st) == ST_RECOVER)); // R5
endmodule

bind rowcache_engine rc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .row_n(row_n), .ref_n(ref_n),
    .q(q), .q_vld(q_vld), .ref_req(ref_req), .st(st), .tag(tag), .fill(fill)
);

// File: tb/rowcache_engine_bench.sv
`timescale 1ns/1ps
module rowcache_engine_bench;
    localparam int ADDR_W = 11;
    localparam int ROW_SEL_W = 2;
    localparam int RECOV = 4;
    localparam int COLS = 1 << ADDR_W;
    localparam int WORDS = COLS / 4;
    localparam int ROWS = 1 << ROW_SEL_W;

    logic clk = 0, rst_n = 0;
    logic cs_n = 0, row_n = 1, wr_sel = 0, ref_n = 1, cal_n = 1, we_n = 1, oe_n = 0, din = 0;
    logic [ADDR_W-1:0] addr = '0;
    logic q, q_vld, ref_req;

    always #4 clk = ~clk;

    rowcache_engine #(.ADDR_W(ADDR_W), .ROW_SEL_W(ROW_SEL_W), .RECOV_CYC(RECOV)) u_rowcache_engine (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .row_n(row_n), .wr_sel(wr_sel), .ref_n(ref_n),
        .cal_n(cal_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
        .q(q), .q_vld(q_vld), .ref_req(ref_req));

    int errors = 0, checks = 0;
    bit done = 0;
    string phase = "R1 reset";

    // behavioural reference; states: 0 idle 1 read 2 wr hit 3 wr miss 4 refresh 5 recover
    logic [COLS-1:0] m_arr [ROWS];
    logic [COLS-1:0] m_cache;
    logic [3:0] m_word;
    int m_st, m_cnt, m_tag, m_slot, m_col_lat;
    bit m_tagv, m_row_q, m_q, m_vld, m_ref;

    always @(posedge clk) begin
        int c, a, hi, lo;
        bit fall, hit, dref, drd, dwr, en;
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) m_arr[i] = '0;
            m_cache = '0; m_word = '0; m_st = 0; m_cnt = 0; m_tag = 0; m_slot = 0;
            m_col_lat = 0; m_tagv = 0; m_row_q = 1; m_q = 0; m_vld = 0; m_ref = 0;
        end else begin
            a = int'(addr);
            c = cal_n ? a : m_col_lat;
            fall = m_row_q && !row_n;
            hit = m_tagv && (a == m_tag);
            dref = fall && !ref_n;
            drd = fall && ref_n && !cs_n && !wr_sel && cal_n;
            dwr = fall && ref_n && !cs_n && wr_sel && cal_n && we_n;
            en = !cs_n && !oe_n && m_st != 3 && m_st != 5 && !(m_st == 0 && dwr && !hit);
            hi = c / WORDS; lo = c % WORDS;
            m_q = en ? m_word[hi] : 1'b0;
            m_vld = en;
            for (int k = 0; k < 4; k++) m_word[k] = m_cache[k*WORDS + lo];
            m_ref = (m_st == 0) && dref;
            if ((m_st == 2 || m_st == 3) && !cs_n && !cal_n && !we_n) begin
                m_arr[m_slot][c] = din;
                if (m_st == 2) m_cache[c] = din;
            end
            case (m_st)
                0: if (dref) m_st = 4;
                   else if (drd) begin
                       if (!hit) begin m_cache = m_arr[a % ROWS]; m_tag = a; m_tagv = 1; end
                       m_st = 1;
                   end else if (dwr) begin m_slot = a % ROWS; m_st = hit ? 2 : 3; end
                1, 2, 4: if (row_n) m_st = 0;
                3: if (row_n) begin m_st = 5; m_cnt = RECOV; end
                default: begin if (m_cnt <= 1) m_st = 0; m_cnt = m_cnt - 1; end
            endcase
            if (cal_n) m_col_lat = a;
            m_row_q = row_n;
        end
    end

    task automatic chk(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", phase, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("q", q, m_q);
            chk("q_vld", q_vld, m_vld);
            chk("ref_req", ref_req, m_ref);
        end
    endtask

    task automatic open_row(int row, bit wr);
        addr = ADDR_W'(row); wr_sel = wr; row_n = 0; cyc(1); wr_sel = 0;
    endtask

    task automatic wr_bit(int c, bit d);
        addr = ADDR_W'(c); cyc(1);
        cal_n = 0; we_n = 0; din = d; cyc(1);
        cal_n = 1; we_n = 1; cyc(1);
    endtask

    task automatic rd_at(int c, int wait_n, bit exp, string tagmsg);
        addr = ADDR_W'(c); cyc(wait_n);
        chk(tagmsg, q, exp);
    endtask

    initial begin
        cyc(3);
        chk("R1 q_vld in reset", q_vld, 1'b0);
        chk("R1 ref_req in reset", ref_req, 1'b0);
        rst_n = 1; cyc(2);

        phase = "R1 R5 R6 write miss row 0";
        open_row(0, 1);
        chk("R1 tag invalid so row 0 misses (q_vld)", q_vld, 1'b0);
        wr_bit(5, 1); wr_bit(600, 1); wr_bit(88, 0);
        addr = 9; cyc(1); cal_n = 0; din = 1; cyc(1);      // latched column 9, we_n high: no commit
        addr = 77; we_n = 0; cyc(1); cal_n = 1; we_n = 1; cyc(1);
        addr = 10; cyc(1); cal_n = 0; din = 1; cyc(1); cal_n = 1; cyc(1);
        chk("R5 muted during write miss", q_vld, 1'b0);
        row_n = 1; cyc(1); cyc(RECOV);
        chk("R5 muted through recovery", q_vld, 1'b0);
        cyc(1);
        chk("R5 output back after recovery", q_vld, 1'b1);

        phase = "R2 R6 read miss row 0";
        open_row(0, 0);
        rd_at(5, 3, 1, "R2 filled bit col 5");
        rd_at(9, 3, 1, "R6 held column 9 written");
        rd_at(77, 3, 0, "R6 col 77 untouched");
        rd_at(10, 3, 0, "R6 we_n high no commit");
        row_n = 1; cyc(1);

        phase = "R4 write hit row 0";
        open_row(0, 1);
        wr_bit(7, 1);
        rd_at(7, 3, 1, "R4 read during write hit");
        chk("R4 valid during hit", q_vld, 1'b1);
        row_n = 1; cyc(1);

        phase = "R9 column paths";
        rd_at(88, 3, 0, "R9 col 88");
        rd_at(600, 1, 1, "R9 top bits only, one cycle");
        rd_at(517, 1, 1, "R9 low bits, still old after one");
        cyc(1); chk("R9 low bits, new after two", q, 1'b0);

        phase = "R3 R10 alias row 4";
        open_row(4, 1);
        chk("R10 row 4 is a miss", q_vld, 1'b0);
        wr_bit(5, 0);
        row_n = 1; cyc(RECOV + 2);
        open_row(0, 0);
        rd_at(5, 3, 1, "R3 hit keeps cache bit");
        row_n = 1; cyc(1);
        open_row(4, 0);
        rd_at(5, 3, 0, "R10 shared slot data");
        rd_at(7, 3, 1, "R10 slot keeps hit write");
        row_n = 1; cyc(1);

        phase = "R8 refresh";
        cs_n = 1; ref_n = 0; row_n = 0; cyc(1);
        chk("R8 ref_req pulse", ref_req, 1'b1);
        cs_n = 0; ref_n = 1; cyc(1);
        chk("R8 single pulse", ref_req, 1'b0);
        rd_at(7, 3, 1, "R8 readable in refresh");
        row_n = 1; cyc(1);

        phase = "R11 ignored edges";
        cs_n = 1; open_row(2, 0); cs_n = 0;
        rd_at(7, 3, 1, "R11 deselected read ignored");
        row_n = 1; cyc(1);
        cal_n = 0; open_row(2, 0); cal_n = 1;
        rd_at(7, 3, 1, "R11 cal low read ignored");
        row_n = 1; cyc(1);
        open_row(9, 1); row_n = 1; cyc(2);
        open_row(2, 0); row_n = 1; cyc(RECOV + 2);
        rd_at(7, 3, 1, "R11 fall in recovery ignored");

        phase = "R7 output enable";
        oe_n = 1; cyc(2);
        chk("R7 oe high invalid", q_vld, 1'b0);
        chk("R7 q zero when invalid", q, 1'b0);
        oe_n = 0; cyc(2);
        chk("R7 re-enabled static read", q, 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule